// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly

This block performs one add-compare-select step of a Viterbi decoder. Two earlier path metrics each receive a branch metric, giving two candidate metrics. The block subtracts the first candidate from the second, one bit wider than a metric. The sign of that difference chooses which candidate survives.

The surviving (smaller) candidate is registered as the new path metric. The one-bit choice is registered as well, so a traceback store can keep it. The signed difference is also given out, for use in metric normalisation or soft-output logic.

Two parameters can add a register stage after the adders and after the subtractor. The decision, metric, difference and valid flag always pass through the same number of stages, so they stay aligned.

Top module: `acs_butterfly`

## Requirements
- R1: Each candidate is the sum of a previous path metric and its branch metric (branch zero-extended), kept modulo 2^METRIC_W: cand_a = prev_metric_a + branch_a, cand_b = prev_metric_b + branch_b.
- R2: `cand_delta` is the METRIC_W+1-bit two's-complement value cand_b - cand_a, computed from zero-extended candidates.
- R3: `surv_sel` equals the top bit (bit METRIC_W) of `cand_delta`. `surv_metric` is cand_b when `surv_sel` is 1 and cand_a when it is 0, so the smaller candidate survives.
- R4: When the two candidates are equal, `surv_sel` is 0 and `surv_metric` is cand_a.
- R5: The choice is correct across the full metric range. With cand_a = 0 and cand_b = 2^METRIC_W-1 the decision is 0. With the two values swapped it is 1.
- R6: A result appears with `out_valid` high exactly 1+PIPE_ADD+PIPE_CMP cycles after the edge that samples `in_valid`. `surv_metric`, `surv_sel` and `cand_delta` belong to the same input.
- R7: In a cycle where `out_valid` is low, `surv_metric`, `surv_sel` and `cand_delta` keep their previous values.
- R8: An active-low synchronous reset clears `out_valid`, `surv_metric`, `surv_sel`, `cand_delta` and every internal stage, even while `in_valid` is high.
- R9: Inputs presented on consecutive cycles give results on consecutive cycles, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the inputs as a new operation |
| prev_metric_a | input | METRIC_W | Previous path metric, first branch |
| prev_metric_b | input | METRIC_W | Previous path metric, second branch |
| branch_a | input | BRANCH_W | Branch metric added to the first path |
| branch_b | input | BRANCH_W | Branch metric added to the second path |
| out_valid | output | 1 | Result outputs hold a new result |
| surv_metric | output | METRIC_W | Surviving (new) path metric |
| surv_sel | output | 1 | Decision bit: 1 when the second candidate survived |
| cand_delta | output | METRIC_W+1 | Signed difference cand_b - cand_a |

## Verification
If the stage registers hold wrong data, the next `out_valid` shows it. The output would carry a metric that is not one of the two candidates, or a decision that disagrees with the sign of `cand_delta`. This happens exactly the configured latency after the bad input.

Misaligned pipelining shows a different way. The result appears a cycle early or late, or the decision belongs to a neighbouring input, and back-to-back traffic exposes it at once. A faulty hold path changes the outputs on a cycle where `out_valid` is low, and the first idle cycle after a result shows this.

// File: rtl/acs_pkg.sv
// Package: shared defaults and helpers for the add-compare-select butterfly.
// Assumes: widths are set per instance; only defaults and latency math live here.
package acs_pkg;
    localparam int unsigned DEF_METRIC_W = 24;
    localparam int unsigned DEF_BRANCH_W = 16;

    // Latency of the butterfly in cycles, given its optional stage flags.
    function automatic int unsigned acs_latency(input bit pipe_add, input bit pipe_cmp);
        return 1 + int'(pipe_add) + int'(pipe_cmp);
    endfunction
endpackage

// File: rtl/acs_pipe_reg.sv
// Module: acs_pipe_reg
// Optional register stage with a valid bit. EN=1 adds one cycle of delay.
// EN=0 passes the input straight through.
// Assumes: synchronous active-low reset clears both valid and data.
module acs_pipe_reg #(
    parameter int unsigned W  = 8,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);
    generate
        if (EN) begin : g_reg
            logic         vld_q;
            logic [W-1:0] dat_q;
            // Capture one stage of valid and data per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else begin
                    vld_q <= in_vld;
                    dat_q <= in_dat;
                end
            end
            assign out_vld = vld_q;
            assign out_dat = dat_q;
        end else begin : g_wire
            assign out_vld = in_vld;
            assign out_dat = in_dat;
        end
    endgenerate
endmodule

// File: rtl/acs_add_stage.sv
// Module: acs_add_stage
// Forms the two candidate metrics, each a path metric plus a branch metric.
// Assumes: metric normalisation is done elsewhere; sums wrap modulo 2^MW.
module acs_add_stage #(
    parameter int unsigned MW = 24,
    parameter int unsigned BW = 16
) (
    input  logic [MW-1:0] pm_a,
    input  logic [MW-1:0] pm_b,
    input  logic [BW-1:0] br_a,
    input  logic [BW-1:0] br_b,
    output logic [MW-1:0] cand_a,
    output logic [MW-1:0] cand_b
);
    // Zero-extend each branch metric and add it to its path metric.
    always_comb begin
        cand_a = pm_a + MW'(br_a);
        cand_b = pm_b + MW'(br_b);
    end
endmodule

// File: rtl/acs_cmp_stage.sv
// Module: acs_cmp_stage
// Subtracts candidate a from candidate b at MW+1 bits.
// Assumes: candidates are unsigned, so the top bit of the result is a true sign.
module acs_cmp_stage #(
    parameter int unsigned MW = 24
) (
    input  logic [MW-1:0] cand_a,
    input  logic [MW-1:0] cand_b,
    output logic [MW:0]   delta
);
    // Widened subtraction; bit MW is set exactly when cand_b < cand_a.
    always_comb begin
        delta = {1'b0, cand_b} - {1'b0, cand_a};
    end
endmodule

// File: rtl/acs_sel_stage.sv
// Module: acs_sel_stage
// Picks the survivor by the sign of the difference, then registers the
// metric, the decision and the difference.
// Assumes: outputs load only on a valid cycle and hold otherwise.
module acs_sel_stage #(
    parameter int unsigned MW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [MW-1:0] cand_a,
    input  logic [MW-1:0] cand_b,
    input  logic [MW:0]   delta,
    output logic          out_vld,
    output logic [MW-1:0] metric_q,
    output logic          sel_q,
    output logic [MW:0]   delta_q
);
    logic          sel_d;
    logic [MW-1:0] metric_d;

    // Sign of the difference drives the 2:1 survivor mux; ties keep cand_a.
    always_comb begin
        sel_d    = delta[MW];
        metric_d = sel_d ? cand_b : cand_a;
    end

    // Output register: load on valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            metric_q <= '0;
            sel_q    <= 1'b0;
            delta_q  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                metric_q <= metric_d;
                sel_q    <= sel_d;
                delta_q  <= delta;
            end
        end
    end
endmodule

// File: rtl/acs_butterfly.sv
// Module: acs_butterfly (top)
// One add-compare-select step: add, optional stage, subtract, optional stage,
// then select and register.
// Assumes: the caller stores surv_sel for traceback; latency is 1+PIPE_ADD+PIPE_CMP.
module acs_butterfly #(
    parameter int unsigned METRIC_W = acs_pkg::DEF_METRIC_W,
    parameter int unsigned BRANCH_W = acs_pkg::DEF_BRANCH_W,
    parameter bit          PIPE_ADD = 1'b1,
    parameter bit          PIPE_CMP = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [METRIC_W-1:0] prev_metric_a,
    input  logic [METRIC_W-1:0] prev_metric_b,
    input  logic [BRANCH_W-1:0] branch_a,
    input  logic [BRANCH_W-1:0] branch_b,
    output logic                out_valid,
    output logic [METRIC_W-1:0] surv_metric,
    output logic                surv_sel,
    output logic [METRIC_W:0]   cand_delta
);
    localparam int unsigned PAIR_W = 2 * METRIC_W;
    localparam int unsigned CMP_W  = PAIR_W + METRIC_W + 1;

    logic [METRIC_W-1:0] add_a, add_b, p1_a, p1_b, p2_a, p2_b;
    logic [METRIC_W:0]   cmp_delta, p2_delta;
    logic                p1_vld, p2_vld;

    acs_add_stage #(.MW(METRIC_W), .BW(BRANCH_W)) u_add (
        .pm_a(prev_metric_a), .pm_b(prev_metric_b),
        .br_a(branch_a), .br_b(branch_b),
        .cand_a(add_a), .cand_b(add_b)
    );

    acs_pipe_reg #(.W(PAIR_W), .EN(PIPE_ADD)) u_pipe_add (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_valid), .in_dat({add_a, add_b}),
        .out_vld(p1_vld), .out_dat({p1_a, p1_b})
    );

    acs_cmp_stage #(.MW(METRIC_W)) u_cmp (
        .cand_a(p1_a), .cand_b(p1_b), .delta(cmp_delta)
    );

    acs_pipe_reg #(.W(CMP_W), .EN(PIPE_CMP)) u_pipe_cmp (
        .clk(clk), .rst_n(rst_n),
        .in_vld(p1_vld), .in_dat({p1_a, p1_b, cmp_delta}),
        .out_vld(p2_vld), .out_dat({p2_a, p2_b, p2_delta})
    );

    acs_sel_stage #(.MW(METRIC_W)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .in_vld(p2_vld), .cand_a(p2_a), .cand_b(p2_b), .delta(p2_delta),
        .out_vld(out_valid), .metric_q(surv_metric),
        .sel_q(surv_sel), .delta_q(cand_delta)
    );
endmodule

// File: rtl/acs_butterfly_chk.sv
// Module: acs_butterfly_chk
// Assertion checker attached to acs_butterfly through bind.
// Assumes: the same parameters as the top instance.
module acs_butterfly_chk #(
    parameter int unsigned MW = 24,
    parameter bit          PA = 1'b1,
    parameter bit          PC = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [MW-1:0] surv_metric,
    input logic          surv_sel,
    input logic [MW:0]   cand_delta
);
    localparam int unsigned LAT = acs_pkg::acs_latency(PA, PC);

    logic [LAT-1:0] vld_sh;
    logic           rst_seen = 1'b0;

    // Reference shift register of in_valid, one bit per cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sh <= '0;
        else        vld_sh <= LAT'({vld_sh, in_valid});
    end

    // R8: one edge after reset was sampled low, every output is cleared.
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_clear_R8: assert (!out_valid && surv_metric == '0 &&
                                           !surv_sel && cand_delta == '0)
                else $error("reset did not clear outputs");
        end
        rst_seen <= !rst_n;
    end

    // R6: out_valid follows in_valid by exactly the configured latency.
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_sh[LAT-1]);

    // R3: the decision agrees with the sign of the reported difference.
    assert_sel_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> surv_sel == cand_delta[MW]);

    // R4: a zero difference always keeps the first candidate.
    assert_tie_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cand_delta == '0) |-> !surv_sel);

    // R7: outputs hold whenever no new result arrives.
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(surv_metric) && $stable(surv_sel) && $stable(cand_delta)));
endmodule

bind acs_butterfly acs_butterfly_chk #(.MW(METRIC_W), .PA(PIPE_ADD), .PC(PIPE_CMP)) u_acs_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .surv_metric(surv_metric), .surv_sel(surv_sel), .cand_delta(cand_delta)
);

// File: tb/test_acs_butterfly.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops and compares.
module test_acs_butterfly;
    localparam int unsigned MW  = 24;
    localparam int unsigned BW  = 16;
    localparam int unsigned LAT = 3;

    typedef struct {
        logic [MW-1:0] metric;
        logic          sel;
        logic [MW:0]   delta;
        int            stamp;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [MW-1:0] pm_a = '0, pm_b = '0;
    logic [BW-1:0] br_a = '0, br_b = '0;
    logic          out_valid, surv_sel;
    logic [MW-1:0] surv_metric;
    logic [MW:0]   cand_delta;

    int checks = 0, failures = 0, cyc = 0;
    bit running = 1'b0;
    exp_t sb[$];
    logic [MW-1:0] last_metric = '0;
    logic          last_sel = 1'b0;
    logic [MW:0]   last_delta = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    acs_butterfly #(.METRIC_W(MW), .BRANCH_W(BW), .PIPE_ADD(1'b1), .PIPE_CMP(1'b1)) i_acs_butterfly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .prev_metric_a(pm_a), .prev_metric_b(pm_b), .branch_a(br_a), .branch_b(br_b),
        .out_valid(out_valid), .surv_metric(surv_metric),
        .surv_sel(surv_sel), .cand_delta(cand_delta)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: present one operation and push its expected result (R1, R2, R3).
    task automatic send(input logic [MW-1:0] a, input logic [MW-1:0] b,
                        input logic [BW-1:0] ba, input logic [BW-1:0] bb);
        exp_t e;
        logic [MW-1:0] ca, cb;
        @(negedge clk);
        pm_a = a; pm_b = b; br_a = ba; br_b = bb; in_valid = 1'b1;
        ca = a + MW'(ba);
        cb = b + MW'(bb);
        e.delta  = {1'b0, cb} - {1'b0, ca};
        e.sel    = (cb < ca);
        e.metric = e.sel ? cb : ca;
        e.stamp  = cyc;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            pm_a = $urandom; pm_b = $urandom;
        end
    endtask

    // Monitor: compare results on valid cycles, check holding on idle ones.
    always @(negedge clk) begin
        if (running) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(surv_metric == e.metric, "R1/R3", "surv_metric", 64'(surv_metric), 64'(e.metric));
                    check(surv_sel == e.sel, "R3", "surv_sel", 64'(surv_sel), 64'(e.sel));
                    check(cand_delta == e.delta, "R2", "cand_delta", 64'(cand_delta), 64'(e.delta));
                    check(cyc - e.stamp == LAT, "R6", "latency", 64'(cyc - e.stamp), 64'(LAT));
                end
            end else begin
                check(surv_metric == last_metric && surv_sel == last_sel && cand_delta == last_delta,
                      "R7", "hold on idle", 64'(surv_metric), 64'(last_metric));
            end
            last_metric = surv_metric;
            last_sel    = surv_sel;
            last_delta  = cand_delta;
        end
    end

    initial begin
        // R8: reset with valid traffic pending must clear all outputs.
        in_valid = 1'b1; pm_a = 24'h123456; pm_b = 24'h000001; br_a = 16'h7; br_b = 16'h9;
        repeat (5) @(negedge clk);
        check(!out_valid, "R8", "out_valid after reset", 64'(out_valid), 0);
        check(surv_metric == '0 && !surv_sel && cand_delta == '0, "R8", "outputs after reset",
              64'(surv_metric), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;
        idle(2);
        // R1/R3: simple cases, each direction.
        send(24'd100, 24'd200, 16'd5, 16'd1);
        idle(4);
        send(24'd500, 24'd100, 16'd10, 16'd20);
        idle(4);
        // R4: equal candidates keep the first.
        send(24'd300, 24'd290, 16'd10, 16'd20);
        idle(4);
        // R5: far-apart candidates in both orders.
        send(24'h000000, 24'hFFFFFF, 16'd0, 16'd0);
        idle(4);
        send(24'hFFFFFF, 24'h000000, 16'd0, 16'd0);
        idle(4);
        // R1: wrap of the candidate sum.
        send(24'hFFFFF0, 24'h000100, 16'h0020, 16'h0001);
        idle(3);
        // R9: back-to-back stream.
        for (int k = 0; k < 24; k++)
            send(MW'(k * 24'h01F3A7 + 24'h0400), MW'(24'hFFF000 - k * 24'h0123C9),
                 BW'(k * 97), BW'(16'hFFFF - k * 311));
        idle(LAT + 4);
        running = 1'b0;
        check(sb.size() == 0, "R9", "all results delivered", 64'(sb.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        check(1'b0, "R6", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule